// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Unit

A synthesizable behavioural model of a small synchronous burst memory with four 8-bit byte lanes and a parameterised depth. All control inputs are taken at the rising clock edge. Output enable and the sleep input are the exceptions: they gate the read data without waiting for a clock. A transfer begins on one of two start strobes, a processor strobe or a controller strobe, and only while all three chip selects are active. After that, a two-bit burst counter walks the low address bits in linear or interleaved order, under control of an advance input.

Writes are posted into a one-entry write buffer and reach the array on the next clock edge. A read that comes straight after a write to the same word merges the buffered bytes into its result, so the newly written data is returned. Read data passes through two registers, so it appears after the second rising edge. A sleep input freezes all state and blanks the outputs. After sleep drops, two clock edges pass before the block accepts any new operation.

Top module: `pbsram_core`

## Requirements
- R1: A start strobe (processor strobe low with `sel1N` low, or controller strobe low) starts a cycle only when `sel1N`=0, `sel2`=1 and `sel3N`=0. A strobe seen with any select inactive deselects the block: it makes no access and ends any burst, so the output goes invalid once the pipeline drains.
- R2: While `sel1N` is high, the processor strobe starts nothing. If no burst is active, the output stays invalid.
- R3: A cycle started by the processor strobe always reads at `addr`. On that edge the write inputs and `dataIn` are ignored.
- R4: A cycle started by the controller strobe requires the processor strobe to be high on the same edge. The write inputs are sampled on that edge, so a write to `addr` with that edge's `dataIn` can start the cycle.
- R5: Write decode works as follows. When `globalWrN`=0, all four lanes are written. Otherwise lane i is written only when `byteWrEnN`=0 and `laneWrN[i]`=0. Lane i is `dataIn[8i+7:8i]`. With `byteWrEnN`=1 and `globalWrN`=1, the cycle is a read.
- R6: Data for a read sampled at edge k is on `dataOut` after edge k+1, with `dataOutValid`=1. Reset clears `dataOutValid`.
- R7: After an edge that performs a write, `dataOutValid` is 0 whatever `outEnN` is. At other times `outEnN`=1 forces `dataOutValid` to 0 at once, with no clock edge needed.
- R8: On an edge with no strobe during an active burst, `advN`=0 advances the two-bit burst count before the access, and `advN`=1 repeats the current address. The count wraps after four accesses.
- R9: The burst low bits are computed from the start low bits b and the count c. With `interleaveMode`=1 they are b XOR c. With `interleaveMode`=0 they are (b + c) mod 4. The upper address bits stay fixed for the whole burst.
- R10: While `sleep`=1, `dataOutValid` is 0 at once and no internal state changes. When `sleep` falls, the previously held output reappears.
- R11: On the first two rising edges after `sleep` falls, every input except `sleep` is ignored, including both strobes.
- R12: A read on the edge directly after a write to the same address returns the written bytes for the written lanes and the old bytes for the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of control and pipeline state |
| addr | input | AW | Word address (AW = clog2(DEPTH)) |
| sel1N | input | 1 | Chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select, active high |
| sel3N | input | 1 | Chip select, active low |
| strobeProcN | input | 1 | Processor start strobe, active low |
| strobeCtrlN | input | 1 | Controller start strobe, active low |
| advN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enable for per-lane writes, active low |
| laneWrN | input | 4 | Per-lane write enables, active low |
| interleaveMode | input | 1 | 1 = interleaved burst order, 0 = linear |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Read data |
| dataOutValid | output | 1 | Read data is being driven |

## Verification
The hardest case to reach from the ports is a partial-lane write followed on the very next edge by a read of the same word. Only in that case does the array still hold stale bytes while the buffer holds new ones. A directed sequence makes a controller-started byte write and then, one edge later, a processor-started read of the same address that also has its write inputs asserted. This checks the lane merge and the ignored write inputs together. Random traffic on only sixteen addresses, with frequent strobes and occasional sleep pulses, makes such write-read pairs, write-in-wake attempts and mid-burst deselects happen repeatedly.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Per-edge command from the control unit to the datapath
  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [LANES-1:0] wrLanes;
    logic             hold;
  } accessCmd_t;
endpackage

// File: rtl/pbsram_burst_ctr.sv
module pbsram_burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] baseLow,
  input  logic          interleave,
  output logic [CW-1:0] curLow,
  output logic [CW-1:0] nextLow
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] baseReg;
  logic [CW-1:0] cntNext;

  function automatic logic [CW-1:0] mapIdx(logic [CW-1:0] b, logic [CW-1:0] c, logic il);
    return il ? (b ^ c) : (b + c);
  endfunction

  assign cntNext = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      baseReg <= '0;
    end else if (load) begin
      cnt     <= '0;
      baseReg <= baseLow;
    end else if (step) begin
      cnt <= cntNext;
    end
  end

  assign curLow  = mapIdx(baseReg, cnt, interleave);
  assign nextLow = mapIdx(baseReg, cntNext, interleave);
endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
  import pbsram_pkg::*;
#(
  parameter int AW          = 8,
  parameter int BURST_W     = 2,
  parameter int WAKE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    addr,
  input  logic             sel1N,
  input  logic             sel2,
  input  logic             sel3N,
  input  logic             strobeProcN,
  input  logic             strobeCtrlN,
  input  logic             advN,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneWrN,
  input  logic             interleaveMode,
  input  logic             sleep,
  output accessCmd_t       cmd,
  output logic [AW-1:0]    accAddr,
  output logic             wakeBusy
);
  localparam int HI_W = AW - BURST_W;
  localparam int WCW  = $clog2(WAKE_CYCLES + 1);

  logic [WCW-1:0]     wakeCnt;
  logic               hold;
  logic               selOk;
  logic               procStart;
  logic               anyStrobe;
  logic               startNow;
  logic               deselNow;
  logic               contNow;
  logic               active;
  logic [HI_W-1:0]    baseHigh;
  logic [LANES-1:0]   laneSel;
  logic [BURST_W-1:0] curLow;
  logic [BURST_W-1:0] nextLow;
  logic               wantWr;

  assign wakeBusy  = (wakeCnt != '0);
  assign hold      = sleep || wakeBusy;
  assign selOk     = !sel1N && sel2 && !sel3N;
  assign procStart = !strobeProcN && !sel1N;
  assign anyStrobe = procStart || !strobeCtrlN;
  assign startNow  = !hold && anyStrobe && selOk;
  assign deselNow  = !hold && anyStrobe && !selOk;
  assign contNow   = !hold && !anyStrobe && active;
  assign laneSel   = !globalWrN ? {LANES{1'b1}} : (!byteWrEnN ? ~laneWrN : '0);

  always_ff @(posedge clk) begin
    if (!rstN)         wakeCnt <= '0;
    else if (sleep)    wakeCnt <= WCW'(WAKE_CYCLES);
    else if (wakeBusy) wakeCnt <= wakeCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      baseHigh <= '0;
    end else if (startNow) begin
      active   <= 1'b1;
      baseHigh <= addr[AW-1:BURST_W];
    end else if (deselNow) begin
      active <= 1'b0;
    end
  end

  pbsram_burst_ctr #(.CW(BURST_W)) uBurst (
    .clk       (clk),
    .rstN      (rstN),
    .load      (startNow),
    .step      (contNow && !advN),
    .baseLow   (addr[BURST_W-1:0]),
    .interleave(interleaveMode),
    .curLow    (curLow),
    .nextLow   (nextLow)
  );

  always_comb begin
    wantWr  = 1'b0;
    accAddr = addr;
    if (startNow) begin
      wantWr = !procStart && (laneSel != '0);
    end else if (contNow) begin
      accAddr = {baseHigh, (advN ? curLow : nextLow)};
      wantWr  = (laneSel != '0);
    end
    cmd.hold    = hold;
    cmd.wrEn    = wantWr;
    cmd.wrLanes = wantWr ? laneSel : '0;
    cmd.rdEn    = (startNow || contNow) && !wantWr;
  end
endmodule

// File: rtl/pbsram_dpath.sv
module pbsram_dpath
  import pbsram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accessCmd_t        cmd,
  input  logic [AW-1:0]     accAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  input  logic              sleep,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutValid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memWord;
  logic [DATA_W-1:0] mergedWord;
  logic              pendValid;
  logic [AW-1:0]     pendAddr;
  logic [LANES-1:0]  pendLanes;
  logic [DATA_W-1:0] pendData;
  logic              hitPend;
  logic              s1Valid;
  logic [DATA_W-1:0] s1Data;
  logic              outValid;
  logic [DATA_W-1:0] outData;

  assign memWord = mem[accAddr];
  assign hitPend = pendValid && (pendAddr == accAddr);

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign mergedWord[l*LANE_W +: LANE_W] = (hitPend && pendLanes[l])
                                          ? pendData[l*LANE_W +: LANE_W]
                                          : memWord[l*LANE_W +: LANE_W];
  end

  // Posted write: the buffered word reaches the array one edge later
  always_ff @(posedge clk) begin
    if (!cmd.hold && pendValid) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendLanes[l]) mem[pendAddr][l*LANE_W +: LANE_W] <= pendData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendLanes <= '0;
      pendData  <= '0;
      s1Valid   <= 1'b0;
      s1Data    <= '0;
      outValid  <= 1'b0;
      outData   <= '0;
    end else if (!cmd.hold) begin
      pendValid <= cmd.wrEn;
      if (cmd.wrEn) begin
        pendAddr  <= accAddr;
        pendLanes <= cmd.wrLanes;
        pendData  <= dataIn;
      end
      s1Valid <= cmd.rdEn;
      if (cmd.rdEn) s1Data <= mergedWord;
      outValid <= s1Valid && !cmd.wrEn;
      if (s1Valid) outData <= s1Data;
    end
  end

  assign dataOut      = outData;
  assign dataOutValid = outValid && !outEnN && !sleep;
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbsram_pkg::*;
#(
  parameter  int DEPTH       = 256,
  parameter  int WAKE_CYCLES = 2,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     addr,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  input  logic              strobeProcN,
  input  logic              strobeCtrlN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              interleaveMode,
  input  logic              outEnN,
  input  logic              sleep,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutValid
);
  accessCmd_t    cmd;
  logic [AW-1:0] accAddr;
  logic          wakeBusy;

  pbsram_ctrl #(.AW(AW), .BURST_W(2), .WAKE_CYCLES(WAKE_CYCLES)) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .addr          (addr),
    .sel1N         (sel1N),
    .sel2          (sel2),
    .sel3N         (sel3N),
    .strobeProcN   (strobeProcN),
    .strobeCtrlN   (strobeCtrlN),
    .advN          (advN),
    .globalWrN     (globalWrN),
    .byteWrEnN     (byteWrEnN),
    .laneWrN       (laneWrN),
    .interleaveMode(interleaveMode),
    .sleep         (sleep),
    .cmd           (cmd),
    .accAddr       (accAddr),
    .wakeBusy      (wakeBusy)
  );

  pbsram_dpath #(.DEPTH(DEPTH), .AW(AW)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .accAddr     (accAddr),
    .dataIn      (dataIn),
    .outEnN      (outEnN),
    .sleep       (sleep),
    .dataOut     (dataOut),
    .dataOutValid(dataOutValid)
  );
endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk
  import pbsram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              sel1N,
  input logic              sel2,
  input logic              sel3N,
  input logic              strobeProcN,
  input logic              strobeCtrlN,
  input logic              globalWrN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutValid,
  input accessCmd_t        cmd,
  input logic              wakeBusy
);
  logic selOk;
  logic strobeSeen;
  assign selOk      = !sel1N && sel2 && !sel3N;
  assign strobeSeen = (!strobeProcN && !sel1N) || !strobeCtrlN;

  AST_DESELECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (strobeSeen && !selOk && !sleep && !wakeBusy) |-> (!cmd.rdEn && !cmd.wrEn)); // R1
  AST_PROC_START_READS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeProcN && selOk && !sleep && !wakeBusy) |-> (cmd.rdEn && !cmd.wrEn)); // R3
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && !globalWrN) |-> (&cmd.wrLanes)); // R5
  AST_WRITE_BLANKS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |=> !dataOutValid); // R7
  AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(dataOut)); // R10
  AST_WAKE_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleep) |-> wakeBusy); // R11
  AST_WAKE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    wakeBusy |-> (!cmd.rdEn && !cmd.wrEn)); // R11
endmodule

bind pbsram_core pbsram_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .sleep       (sleep),
  .sel1N       (sel1N),
  .sel2        (sel2),
  .sel3N       (sel3N),
  .strobeProcN (strobeProcN),
  .strobeCtrlN (strobeCtrlN),
  .globalWrN   (globalWrN),
  .dataOut     (dataOut),
  .dataOutValid(dataOutValid),
  .cmd         (cmd),
  .wakeBusy    (wakeBusy)
);

// File: tb/pbsram_core_test.sv
module pbsram_core_test;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic        sel1N = 1'b0, sel2 = 1'b1, sel3N = 1'b0;
  logic        strobeProcN = 1'b1, strobeCtrlN = 1'b1, advN = 1'b1;
  logic        globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [3:0]  laneWrN = 4'hF;
  logic        interleaveMode = 1'b0, outEnN = 1'b0, sleep = 1'b0;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dataOutValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pbsram_core #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .strobeProcN(strobeProcN), .strobeCtrlN(strobeCtrlN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .interleaveMode(interleaveMode), .outEnN(outEnN), .sleep(sleep),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  // Reference model state, built from the requirements
  logic [31:0] mMem [DEPTH];
  bit          mActive;
  logic [7:0]  mBase;
  logic [1:0]  mCnt;
  int          mWake;
  bit          mPendV;
  logic [7:0]  mPendA;
  logic [3:0]  mPendL;
  logic [31:0] mPendD;
  bit          mS1V;
  logic [31:0] mS1D;
  bit          mOutV;
  logic [31:0] mOutD;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] burstLow(logic [1:0] b, logic [1:0] c, logic il);
    return il ? (b ^ c) : (b + c);
  endfunction

  task automatic modelEdge();
    bit proc, anyS, selOk, rd, wr;
    logic [7:0]  a;
    logic [3:0]  ln;
    logic [31:0] rv;
    if (!rstN) begin
      mActive = 0; mBase = '0; mCnt = '0; mWake = 0; mPendV = 0;
      mS1V = 0; mOutV = 0; mOutD = '0;
      return;
    end
    if (sleep) begin mWake = 2; return; end
    if (mWake > 0) begin mWake--; return; end
    proc  = !strobeProcN && !sel1N;
    anyS  = proc || !strobeCtrlN;
    selOk = !sel1N && sel2 && !sel3N;
    ln    = !globalWrN ? 4'hF : (!byteWrEnN ? ~laneWrN : 4'h0);
    rd = 0; wr = 0; a = addr;
    if (anyS && selOk) begin
      mActive = 1; mBase = addr; mCnt = 0;
      wr = !proc && (ln != 0); rd = !wr;
    end else if (anyS) begin
      mActive = 0;
    end else if (mActive) begin
      if (!advN) mCnt = mCnt + 1;
      a  = {mBase[7:2], burstLow(mBase[1:0], mCnt, interleaveMode)};
      wr = (ln != 0); rd = !wr;
    end
    rv = mMem[a];
    if (mPendV && mPendA == a)
      for (int l = 0; l < 4; l++) if (mPendL[l]) rv[l*8 +: 8] = mPendD[l*8 +: 8];
    if (mPendV)
      for (int l = 0; l < 4; l++) if (mPendL[l]) mMem[mPendA][l*8 +: 8] = mPendD[l*8 +: 8];
    mOutV = mS1V && !wr;
    if (mS1V) mOutD = mS1D;
    mS1V = rd;
    if (rd) mS1D = rv;
    mPendV = wr;
    if (wr) begin mPendA = a; mPendL = ln; mPendD = dataIn; end
  endtask

  task automatic compareOut();
    bit expV;
    expV = mOutV && !outEnN && !sleep;
    check(dataOutValid === expV, "R6 R7 model valid", {31'd0, dataOutValid}, {31'd0, expV});
    if (expV && dataOutValid)
      check(dataOut === mOutD, "R6 R12 model data", dataOut, mOutD);
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    #1;
    compareOut();
  endtask

  task automatic idleIn();
    sel1N = 0; sel2 = 1; sel3N = 0; strobeProcN = 1; strobeCtrlN = 1; advN = 1;
    globalWrN = 1; byteWrEnN = 1; laneWrN = 4'hF; outEnN = 0; sleep = 0;
  endtask

  task automatic ctrlWrite(logic [7:0] a, logic [31:0] d, bit useGlobal, logic [3:0] lnN);
    idleIn(); addr = a; strobeCtrlN = 0; dataIn = d;
    if (useGlobal) globalWrN = 0;
    else begin byteWrEnN = 0; laneWrN = lnN; end
    tick();
  endtask

  task automatic procRead(logic [7:0] a);
    idleIn(); addr = a; strobeProcN = 0; tick();
  endtask

  task automatic deselect();
    idleIn(); strobeCtrlN = 0; sel2 = 0; tick();
  endtask

  task automatic holdTick(logic adv);
    idleIn(); advN = adv; tick();
  endtask

  task automatic expectOut(string tag, logic [31:0] exp);
    check(dataOutValid === 1'b1 && dataOut === exp, tag, dataOutValid ? dataOut : 32'hxxxx_xxxx, exp);
  endtask

  task automatic expectOff(string tag);
    check(dataOutValid === 1'b0, tag, {31'd0, dataOutValid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    void'($urandom(32'd20250));
    idleIn();
    rstN = 0;
    tick(); tick();
    expectOff("R6 reset");
    rstN = 1;

    for (int i = 0; i < 16; i++) ctrlWrite(i[7:0], $urandom, 1'b1, 4'hF);
    for (int i = 0; i < 4; i++) ctrlWrite(8'h30 + i[7:0], 32'h5A00_0030 + i, 1'b1, 4'hF);

    // R4: controller start writes on its own edge
    ctrlWrite(8'h20, 32'h1122_3344, 1'b1, 4'hF);
    deselect();
    procRead(8'h20);
    holdTick(1'b1);
    expectOut("R4 controller write readback", 32'h1122_3344);

    // R12 / R3: partial write then immediate read with write inputs asserted
    deselect();
    ctrlWrite(8'h20, 32'hAABB_CCDD, 1'b0, 4'b1010);
    idleIn(); addr = 8'h20; strobeProcN = 0; globalWrN = 0; dataIn = 32'hFFFF_FFFF; tick();
    holdTick(1'b1);
    expectOut("R12 forwarded lanes", 32'h11BB_33DD);
    deselect();
    procRead(8'h20);
    holdTick(1'b1);
    expectOut("R3 write inputs ignored on processor start", 32'h11BB_33DD);

    // R5: byte-write enable high means read
    deselect();
    idleIn(); addr = 8'h20; strobeCtrlN = 0; laneWrN = 4'h0; dataIn = 32'h0; tick();
    holdTick(1'b1);
    expectOut("R5 read when byte enable high", 32'h11BB_33DD);

    // R8: linear burst, wrap and suspend
    deselect();
    interleaveMode = 0;
    procRead(8'h31);
    holdTick(1'b0); expectOut("R8 linear step0", 32'h5A00_0031);
    holdTick(1'b0); expectOut("R8 linear step1", 32'h5A00_0032);
    holdTick(1'b0); expectOut("R8 linear step2", 32'h5A00_0033);
    holdTick(1'b0); expectOut("R8 linear step3", 32'h5A00_0030);
    holdTick(1'b1); expectOut("R8 wrap to start", 32'h5A00_0031);
    holdTick(1'b1); expectOut("R8 suspend repeats", 32'h5A00_0031);

    // R9: interleaved order
    deselect();
    interleaveMode = 1;
    procRead(8'h32);
    holdTick(1'b0); expectOut("R9 interleave first", 32'h5A00_0032);
    holdTick(1'b0); expectOut("R9 interleave second", 32'h5A00_0033);
    holdTick(1'b0); expectOut("R9 interleave third", 32'h5A00_0030);
    holdTick(1'b0); expectOut("R9 interleave fourth", 32'h5A00_0031);
    interleaveMode = 0;

    // R1: strobe with an inactive select deselects
    deselect();
    procRead(8'h30);
    idleIn(); sel3N = 1; strobeProcN = 0; tick();
    expectOut("R1 pipeline drains", 32'h5A00_0030);
    holdTick(1'b0);
    expectOff("R1 no access after deselect");

    // R2: processor strobe blocked by sel1N high
    deselect(); deselect();
    idleIn(); sel1N = 1; strobeProcN = 0; addr = 8'h30; tick();
    holdTick(1'b1);
    expectOff("R2 blocked processor strobe");

    // R10 / R11: sleep and wake window
    deselect();
    procRead(8'h33);
    holdTick(1'b1);
    expectOut("R6 two-edge read", 32'h5A00_0033);
    sleep = 1; #1;
    expectOff("R10 sleep blanks output");
    for (int i = 0; i < 3; i++) begin idleIn(); sleep = 1; tick(); end
    sleep = 0; #1;
    expectOut("R10 state kept across sleep", 32'h5A00_0033);
    ctrlWrite(8'h33, 32'hDEAD_BEEF, 1'b1, 4'hF);
    ctrlWrite(8'h33, 32'hDEAD_BEEF, 1'b1, 4'hF);
    deselect();
    procRead(8'h33);
    holdTick(1'b1);
    expectOut("R11 strobes ignored while waking", 32'h5A00_0033);

    // R7: output enable and write blanking
    deselect();
    procRead(8'h20);
    idleIn(); outEnN = 1; tick();
    expectOff("R7 output enable high");
    outEnN = 0; #1;
    expectOut("R7 output enable async", 32'h11BB_33DD);
    idleIn(); globalWrN = 0; dataIn = 32'h0102_0304; tick();
    expectOff("R7 write blanks output");

    // Random traffic on a small address window
    for (int n = 0; n < 4000; n++) begin
      sel1N       = ($urandom % 10) == 0;
      sel2        = ($urandom % 12) != 0;
      sel3N       = ($urandom % 12) == 0;
      strobeProcN = ($urandom % 6) != 0;
      strobeCtrlN = ($urandom % 6) != 0;
      advN        = $urandom % 2;
      globalWrN   = ($urandom % 6) != 0;
      byteWrEnN   = ($urandom % 3) != 0;
      laneWrN     = 4'($urandom);
      outEnN      = ($urandom % 5) == 0;
      sleep       = ($urandom % 30) == 0;
      addr        = 8'($urandom % 16);
      dataIn      = $urandom;
      if (($urandom % 64) == 0) interleaveMode = ~interleaveMode;
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule